// File: doc/BRIEF.md
# Rate-Selectable Punctured Convolutional Encoder (K = 7)

This block turns a stream of information bits into a forward-error-correction coded stream using a constraint-length-7 convolutional code. On every clock in which an information bit is accepted, the bit enters a six-stage memory. At the same time, two or three parity bits are formed from the new bit and that memory. In the high-rate modes, some of those parity bits are dropped according to a fixed periodic deletion pattern. The bits that remain are packed into words of a parameterised width and flagged with a one-cycle valid strobe.

Information bits arrive either one per clock on a single-bit port, or as whole bytes. In the byte variant, each accepted byte is spread over eight consecutive clocks. The code rate is a static configuration input and is changed only while the block is held in reset. The output word width is a parameter, so it can match whatever consumes the coded stream.

Top module: `conv_punct_encoder`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears the encoder memory to zero, restarts the deletion pattern at phase 0, empties the packer and drives out_valid and out_data to 0. In the byte variant it also leaves in_ready high. rate_sel is changed only while rst is high. After reset, the inputs 1,0,0,0 at rate code 0 produce the word 8'hF7.
- R2: rate_sel = 0 selects rate 1/2. Each information bit yields two coded bits: first the parity under generator 171 (octal), then the parity under generator 133 (octal). The generator MSB multiplies the current input bit, and each lower bit multiplies the previous inputs, newest first.
- R3: rate_sel = 1 selects rate 1/3. Each information bit yields three coded bits in this order: generator 171, generator 133, generator 165 (octal).
- R4: rate_sel = 2 selects rate 2/3. The keep pattern is 10 for the 171 row and 11 for the 133 row, with the leftmost character at phase 0. A kept 171 bit precedes a kept 133 bit of the same information bit.
- R5: rate_sel = 3 selects rate 3/4, with keep rows 101 (generator 171) and 110 (generator 133).
- R6: rate_sel = 4 selects rate 5/6, with keep rows 10101 (generator 171) and 11010 (generator 133).
- R7: rate_sel = 5 selects rate 7/8, with keep rows 1000101 (generator 171) and 1111010 (generator 133).
- R8: Kept coded bits fill out_data from bit 0 upward, in the order they are produced. Bits left over from a full word start the next word. out_valid is high for exactly one cycle: the cycle after the clock edge that accepts the information bit completing OUT_W kept bits. It is never high otherwise.
- R9: A clock in which no information bit is accepted changes neither the encoder memory nor the deletion phase, and produces no output word. In the serial variant this is any clock with in_valid low.
- R10: In the byte variant, a byte is accepted when in_valid and in_ready are both high. Its bits are encoded MSB first, one per clock, starting at the accepting edge. in_ready stays low for the seven cycles after acceptance, and in_valid or in_data during that time has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rate_sel | input | 3 | Code rate select (0: 1/2, 1: 1/3, 2: 2/3, 3: 3/4, 4: 5/6, 5: 7/8) |
| in_valid | input | 1 | Information input present |
| in_data | input | IN_W (1 serial, 8 byte) | Information bit, or byte encoded MSB first |
| in_ready | output | 1 | Block can accept input (always high in serial variant) |
| out_valid | output | 1 | One-cycle strobe: out_data holds a full packed word |
| out_data | output | OUT_W | Packed kept coded bits, first bit in bit 0 |

## Verification
At every rate, the encoder is driven with mixed data words, a lone impulse and a long run of ones followed by zeros. The impulse exposes each generator's taps one by one. The runs show whether memory and parity order agree. At the punctured rates, several patterns are used so that every deletion phase is reached more than once. Some runs insert idle gaps, which shows whether the memory and the deletion phase hold still when no bit arrives. In the byte variant, junk data is presented while in_ready is low, which separates correct acceptance from double-loading and from LSB-first ordering.

// File: rtl/conv_enc_pkg.sv
package conv_enc_pkg;

   localparam int CONSTRAINT = 7;
   localparam int MEM_W      = CONSTRAINT - 1;
   localparam int MAX_PERIOD = 7;
   localparam int PHASE_W    = $clog2(MAX_PERIOD + 1);

   localparam logic [CONSTRAINT-1:0] POLY_A = 7'o171;
   localparam logic [CONSTRAINT-1:0] POLY_B = 7'o133;
   localparam logic [CONSTRAINT-1:0] POLY_C = 7'o165;

   localparam logic [2:0] RATE_HALF  = 3'd0;
   localparam logic [2:0] RATE_THIRD = 3'd1;
   localparam logic [2:0] RATE_2_3   = 3'd2;
   localparam logic [2:0] RATE_3_4   = 3'd3;
   localparam logic [2:0] RATE_5_6   = 3'd4;
   localparam logic [2:0] RATE_7_8   = 3'd5;

   typedef struct packed {
      logic [2:0] bits;
      logic [1:0] cnt;
   } coded_t;

   function automatic logic is_punctured(input logic [2:0] r);
      return (r >= RATE_2_3) && (r <= RATE_7_8);
   endfunction

   function automatic logic [PHASE_W-1:0] period_of(input logic [2:0] r);
      case (r)
         RATE_2_3: return PHASE_W'(2);
         RATE_3_4: return PHASE_W'(3);
         RATE_5_6: return PHASE_W'(5);
         RATE_7_8: return PHASE_W'(7);
         default:  return PHASE_W'(1);
      endcase
   endfunction

   // bit i of the mask = keep decision at phase i
   function automatic logic [MAX_PERIOD-1:0] keep_a_of(input logic [2:0] r);
      case (r)
         RATE_2_3: return 7'b0000001;
         RATE_3_4: return 7'b0000101;
         RATE_5_6: return 7'b0010101;
         RATE_7_8: return 7'b1010001;
         default:  return '1;
      endcase
   endfunction

   function automatic logic [MAX_PERIOD-1:0] keep_b_of(input logic [2:0] r);
      case (r)
         RATE_2_3: return 7'b0000011;
         RATE_3_4: return 7'b0000011;
         RATE_5_6: return 7'b0001011;
         RATE_7_8: return 7'b0101111;
         default:  return '1;
      endcase
   endfunction

endpackage

// File: rtl/conv_byte_feed.sv
module conv_byte_feed #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_data,
   output logic              in_ready,
   output logic              step,
   output logic              bit_out
);
   localparam int LEFT_W = $clog2(BYTE_W);

   logic [BYTE_W-2:0] hold;
   logic [LEFT_W-1:0] left;
   logic              accept;

   assign in_ready = (left == '0);
   assign accept   = in_valid && in_ready;
   assign step     = accept || (left != '0);
   assign bit_out  = accept ? in_data[BYTE_W-1] : hold[BYTE_W-2];

   always_ff @(posedge clk) begin
      if (rst) begin
         hold <= '0;
         left <= '0;
      end else if (accept) begin
         hold <= in_data[BYTE_W-2:0];
         left <= LEFT_W'(BYTE_W - 1);
      end else if (left != '0) begin
         hold <= {hold[BYTE_W-3:0], 1'b0};
         left <= left - 1'b1;
      end
   end

   assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> !in_ready);
   assert_ready_after_last_R10: assert property (@(posedge clk) disable iff (rst)
      (left == LEFT_W'(1)) |=> in_ready);
   assert_fed_while_busy_R10: assert property (@(posedge clk) disable iff (rst)
      !in_ready |-> step);

endmodule

// File: rtl/conv_trellis_gen.sv
module conv_trellis_gen
   import conv_enc_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic [2:0] rate,
   input  logic       step,
   input  logic       bit_in,
   output coded_t     coded
);
   logic [MEM_W-1:0]      sr;
   logic [PHASE_W-1:0]    phase;
   logic [CONSTRAINT-1:0] win;
   logic [PHASE_W-1:0]    period;
   logic                  pa, pb, pc, ka, kb;

   assign win    = {bit_in, sr};
   assign pa     = ^(win & POLY_A);
   assign pb     = ^(win & POLY_B);
   assign pc     = ^(win & POLY_C);
   assign period = period_of(rate);
   assign ka     = keep_a_of(rate)[phase];
   assign kb     = keep_b_of(rate)[phase];

   always_comb begin
      if (rate == RATE_THIRD) begin
         coded.bits = {pc, pb, pa};
         coded.cnt  = 2'd3;
      end else if (is_punctured(rate)) begin
         if (ka && kb) begin
            coded.bits = {1'b0, pb, pa};
            coded.cnt  = 2'd2;
         end else if (ka) begin
            coded.bits = {2'b00, pa};
            coded.cnt  = 2'd1;
         end else begin
            coded.bits = {2'b00, pb};
            coded.cnt  = 2'd1;
         end
      end else begin
         coded.bits = {1'b0, pb, pa};
         coded.cnt  = 2'd2;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sr    <= '0;
         phase <= '0;
      end else if (step) begin
         sr <= {bit_in, sr[MEM_W-1:1]};
         if (is_punctured(rate))
            phase <= (phase == period - 1'b1) ? '0 : phase + 1'b1;
      end
   end

   assert_phase_in_range_R4: assert property (@(posedge clk) disable iff (rst)
      phase < period);
   assert_punct_keeps_bits_R5: assert property (@(posedge clk) disable iff (rst)
      (step && is_punctured(rate)) |-> (coded.cnt != 2'd0 && coded.cnt != 2'd3));
   assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
      !step |=> ($stable(sr) && $stable(phase)));

endmodule

// File: rtl/conv_word_packer.sv
module conv_word_packer
   import conv_enc_pkg::*;
#(
   parameter int OUT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step,
   input  coded_t           coded,
   output logic             out_valid,
   output logic [OUT_W-1:0] out_data
);
   localparam int WIDE  = OUT_W + 3;
   localparam int CNT_W = $clog2(WIDE + 1);

   generate
      if (OUT_W < 3 || OUT_W > 64) begin : g_bad_width
         $error("conv_word_packer: OUT_W must lie in 3..64");
      end
   endgenerate

   logic [OUT_W-1:0] acc;
   logic [CNT_W-1:0] fill;
   logic [WIDE-1:0]  wide;
   logic [CNT_W-1:0] total;
   logic             full;

   assign wide  = WIDE'(acc) | (WIDE'(coded.bits) << fill);
   assign total = fill + CNT_W'(coded.cnt);
   assign full  = total >= CNT_W'(OUT_W);

   always_ff @(posedge clk) begin
      if (rst) begin
         acc       <= '0;
         fill      <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= 1'b0;
         if (step) begin
            if (full) begin
               out_data  <= wide[OUT_W-1:0];
               acc       <= OUT_W'(wide >> OUT_W);
               fill      <= total - CNT_W'(OUT_W);
               out_valid <= 1'b1;
            end else begin
               acc  <= wide[OUT_W-1:0];
               fill <= total;
            end
         end
      end
   end

   assert_fill_below_word_R8: assert property (@(posedge clk) disable iff (rst)
      fill < CNT_W'(OUT_W));
   assert_valid_needs_step_R8: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(step));
   assert_idle_no_word_R9: assert property (@(posedge clk) disable iff (rst)
      !step |=> !out_valid);

endmodule

// File: rtl/conv_punct_encoder.sv
module conv_punct_encoder
   import conv_enc_pkg::*;
#(
   parameter int OUT_W     = 8,
   parameter bit BYTE_MODE = 1'b0,
   localparam int IN_W     = BYTE_MODE ? 8 : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [2:0]       rate_sel,
   input  logic             in_valid,
   input  logic [IN_W-1:0]  in_data,
   output logic             in_ready,
   output logic             out_valid,
   output logic [OUT_W-1:0] out_data
);
   logic   step;
   logic   bit_in;
   coded_t coded;

   generate
      if (BYTE_MODE) begin : g_byte
         conv_byte_feed #(.BYTE_W(IN_W)) u_feed (
            .clk      (clk),
            .rst      (rst),
            .in_valid (in_valid),
            .in_data  (in_data),
            .in_ready (in_ready),
            .step     (step),
            .bit_out  (bit_in)
         );
      end else begin : g_serial
         assign in_ready = 1'b1;
         assign step     = in_valid;
         assign bit_in   = in_data[0];
      end
   endgenerate

   conv_trellis_gen u_gen (
      .clk    (clk),
      .rst    (rst),
      .rate   (rate_sel),
      .step   (step),
      .bit_in (bit_in),
      .coded  (coded)
   );

   conv_word_packer #(.OUT_W(OUT_W)) u_pack (
      .clk       (clk),
      .rst       (rst),
      .step      (step),
      .coded     (coded),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   assert_rate_static_R1: assert property (@(posedge clk) disable iff (rst)
      $stable(rate_sel));

endmodule

// File: tb/conv_punct_encoder_test.sv
`timescale 1ns/1ps
module conv_punct_encoder_test;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] rate_s = 3'd0, rate_b = 3'd0;
   logic       v_s = 1'b0, d_s = 1'b0, v_b = 1'b0;
   logic [7:0] d_b = 8'h00;
   logic       rdy_s, ov_s, rdy_b, ov_b;
   logic [7:0] od_s, od_b;

   always #2 clk = ~clk;

   conv_punct_encoder #(.OUT_W(8), .BYTE_MODE(1'b0)) uut (
      .clk(clk), .rst(rst), .rate_sel(rate_s), .in_valid(v_s), .in_data(d_s),
      .in_ready(rdy_s), .out_valid(ov_s), .out_data(od_s));

   conv_punct_encoder #(.OUT_W(8), .BYTE_MODE(1'b1)) uut_byte (
      .clk(clk), .rst(rst), .rate_sel(rate_b), .in_valid(v_b), .in_data(d_b),
      .in_ready(rdy_b), .out_valid(ov_b), .out_data(od_b));

   typedef struct packed {
      logic [2:0]  rate;
      logic [31:0] pat;
      logic [5:0]  nb;
      logic        gaps;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{3'd0, 32'hB4E1_0F3C, 6'd32, 1'b0},
      '{3'd0, 32'h8000_0000, 6'd24, 1'b0},
      '{3'd1, 32'hDEAD_BEEF, 6'd32, 1'b1},
      '{3'd1, 32'hFFFF_0000, 6'd32, 1'b0},
      '{3'd2, 32'hA5A5_5A5A, 6'd32, 1'b1},
      '{3'd3, 32'h1234_5678, 6'd30, 1'b0},
      '{3'd4, 32'hFFFF_0000, 6'd32, 1'b1},
      '{3'd5, 32'hC3C3_96E1, 6'd32, 1'b0}
   };

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;
   logic [5:0] mst [2];
   int mph [2];
   bit q0 [$];
   bit q1 [$];

   function automatic string rtag(input int r);
      case (r)
         0: return "R2";
         1: return "R3";
         2: return "R4";
         3: return "R5";
         4: return "R6";
         default: return "R7";
      endcase
   endfunction

   function automatic string pat_a(input int r);
      case (r)
         2: return "10";
         3: return "101";
         4: return "10101";
         default: return "1000101";
      endcase
   endfunction

   function automatic string pat_b(input int r);
      case (r)
         2: return "11";
         3: return "110";
         4: return "11010";
         default: return "1111010";
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic put(input int idx, input bit b);
      if (idx == 0) q0.push_back(b);
      else q1.push_back(b);
   endtask

   task automatic model_push(input int idx, input bit u, input int r);
      logic [6:0] w;
      bit a, b, c;
      string sa, sb;
      w = {u, mst[idx]};
      a = ^(w & 7'o171);
      b = ^(w & 7'o133);
      c = ^(w & 7'o165);
      if (r == 1) begin
         put(idx, a); put(idx, b); put(idx, c);
      end else if (r >= 2 && r <= 5) begin
         sa = pat_a(r);
         sb = pat_b(r);
         if (sa[mph[idx]] == "1") put(idx, a);
         if (sb[mph[idx]] == "1") put(idx, b);
         mph[idx] = (mph[idx] + 1) % sa.len();
      end else begin
         put(idx, a); put(idx, b);
      end
      mst[idx] = {u, mst[idx][5:1]};
   endtask

   task automatic monitor();
      logic [7:0] w;
      if (ov_s) begin
         if (q0.size() < 8) chk(1'b0, "R8 serial strobe without full word", 32'(q0.size()), 32'd8);
         else begin
            for (int i = 0; i < 8; i++) w[i] = q0.pop_front();
            chk(od_s == w, {rtag(rate_s), "/R8 serial word"}, 32'(od_s), 32'(w));
         end
      end
      if (ov_b) begin
         if (q1.size() < 8) chk(1'b0, "R10 byte strobe without full word", 32'(q1.size()), 32'd8);
         else begin
            for (int i = 0; i < 8; i++) w[i] = q1.pop_front();
            chk(od_b == w, "R10 byte-variant word", 32'(od_b), 32'(w));
         end
      end
   endtask

   task automatic cyc();
      @(negedge clk);
      monitor();
   endtask

   task automatic do_reset(input int rs, input int rb);
      rst = 1'b1; v_s = 1'b0; v_b = 1'b0;
      q0.delete(); q1.delete();
      cyc();
      rate_s = 3'(rs); rate_b = 3'(rb);
      cyc();
      q0.delete(); q1.delete();
      mst[0] = '0; mst[1] = '0; mph[0] = 0; mph[1] = 0;
      rst = 1'b0;
   endtask

   task automatic send_s(input bit u);
      v_s = 1'b1; d_s = u;
      model_push(0, u, int'(rate_s));
      cyc();
      v_s = 1'b0;
   endtask

   task automatic send_b(input logic [7:0] by, input logic [7:0] junk);
      v_b = 1'b1; d_b = by;
      for (int i = 7; i >= 0; i--) model_push(1, by[i], int'(rate_b));
      cyc();
      d_b = junk;
      for (int k = 0; k < 7; k++) begin
         chk(rdy_b == 1'b0, "R10 in_ready low while byte drains", 32'(rdy_b), 32'd0);
         cyc();
      end
      chk(rdy_b == 1'b1, "R10 in_ready back after eighth bit", 32'(rdy_b), 32'd1);
      v_b = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      mst[0] = '0; mst[1] = '0; mph[0] = 0; mph[1] = 0;
      do_reset(0, 0);
      // R1: reset state at the ports
      chk(ov_s == 1'b0, "R1 out_valid after reset", 32'(ov_s), 32'd0);
      chk(od_s == 8'h00, "R1 out_data after reset", 32'(od_s), 32'd0);
      chk(rdy_b == 1'b1, "R1 byte in_ready after reset", 32'(rdy_b), 32'd1);
      chk(rdy_s == 1'b1, "R1 serial in_ready", 32'(rdy_s), 32'd1);

      // table walk over rates and patterns
      for (int e = 0; e < 8; e++) begin
         do_reset(int'(VECS[e].rate), 0);
         for (int i = 0; i < int'(VECS[e].nb); i++) begin
            send_s(VECS[e].pat[31-i]);
            if (VECS[e].gaps && (i % 3 == 2)) begin
               d_s = ~d_s;
               cyc(); cyc();
            end
         end
         cyc();
         chk(q0.size() < 8, {rtag(int'(VECS[e].rate)), "/R8 no word left unsent"}, 32'(q0.size()), 32'd7);
      end

      // R1: reset mid-stream restarts from zero memory
      do_reset(0, 0);
      repeat (5) send_s(1'b1);
      do_reset(0, 0);
      chk(ov_s == 1'b0 && od_s == 8'h00, "R1 outputs cleared by reset mid-stream", 32'(od_s), 32'd0);
      send_s(1'b1); send_s(1'b0); send_s(1'b0); send_s(1'b0);
      chk(ov_s == 1'b1 && od_s == 8'hF7, "R1 first word after reset", {23'd0, ov_s, od_s}, 32'h1F7);

      // R9: long idle with toggling data keeps state and emits nothing
      do_reset(3, 0);
      for (int i = 0; i < 10; i++) send_s(1'(i % 2 == 0));
      for (int i = 0; i < 25; i++) begin
         d_s = 1'(i % 2);
         cyc();
         chk(ov_s == 1'b0, "R9 no word while idle", 32'(ov_s), 32'd0);
      end
      for (int i = 0; i < 14; i++) send_s(1'(i % 3 == 0));
      cyc();
      chk(q0.size() < 8, "R9 stream continues after idle", 32'(q0.size()), 32'd7);

      // R10: byte variant, junk offered while busy
      do_reset(0, 0);
      send_b(8'hB4, 8'hFF);
      send_b(8'h01, 8'h00);
      cyc();
      send_b(8'h7E, 8'hAA);
      cyc();
      chk(q1.size() < 8, "R10 all byte words delivered", 32'(q1.size()), 32'd7);
      do_reset(0, 5);
      send_b(8'h96, 8'h69);
      send_b(8'hC3, 8'h3C);
      send_b(8'h0F, 8'hF0);
      send_b(8'h55, 8'hFF);
      cyc();
      chk(q1.size() < 8, "R10 byte words at rate 7/8", 32'(q1.size()), 32'd7);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule